// File: doc/BRIEF.md
# Branch-Resolving Instruction Fetch Unit

This block produces the fetch address and the fetch-to-decode pipeline register for a five-stage in-order core in which branch outcomes are known at the end of decode. Each unstalled cycle it either steps the program counter by one 4-byte word or, when the instruction now sitting in decode is a taken branch, jumps to that branch's target. The target is formed from the branch's own incremented address plus a signed 16-bit word offset.

Two policies govern the single instruction that has already been fetched behind a taken branch. In squash mode the fetch continues on the fall-through path until a branch proves taken, and that one wrong-path word is turned into a bubble. In delay mode that word is an architectural delay slot and always goes on to decode. The policy is chosen by a mode pin that is captured only while reset is held. A stall input freezes the counter and the decode register together. The instruction memory is external and answers in the same cycle.

Top module: `fu_fetch_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the next state has `fetch_addr_o` = 0, `ifid_valid_o` = 0, `ifid_instr_o` = 0 and `ifid_pc4_o` = 0. Reset takes priority over stall and branch inputs.
- R2: With no stall and no accepted branch, each edge moves `fetch_addr_o` up by 4 and loads the decode register with `instr_i`, the old fetch address plus 4, and valid = 1.
- R3: The branch target is `ifid_pc4_o` plus `br_offset_i` sign-extended to the address width and shifted left by two bits, so negative offsets jump backwards.
- R4: In squash mode (`mode_i` = 0 at reset), an accepted taken branch loads the target into the fetch address and clears `ifid_valid_o` and `ifid_instr_o` at the same edge.
- R5: In delay mode (`mode_i` = 1 at reset), an accepted taken branch loads the target into the fetch address while the decode register still takes the word fetched behind the branch, with valid = 1 and a saved incremented address equal to the old fetch address plus 4.
- R6: `br_taken_i` is accepted only when `ifid_valid_o` is 1; while the decode register holds a bubble it has no effect and fetch proceeds sequentially.
- R7: While `stall_i` is high (and reset is low), the fetch address and all three decode-register fields hold their values, and a taken branch is not acted on; it is acted on at the first unstalled edge.
- R8: The policy is taken from `mode_i` only at edges where `rst` is high; changes of `mode_i` at other times have no effect on branch handling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 1 | Branch policy, captured during reset: 0 squash, 1 delay slot |
| stall_i | input | 1 | Freeze the fetch address and decode register this cycle |
| br_taken_i | input | 1 | The instruction in decode is a taken branch |
| br_offset_i | input | 16 | Signed word offset of the branch in decode |
| instr_i | input | 32 | Instruction word read at `fetch_addr_o` |
| fetch_addr_o | output | 32 | Current fetch byte address |
| ifid_instr_o | output | 32 | Instruction held for decode |
| ifid_pc4_o | output | 32 | Address following the instruction held for decode |
| ifid_valid_o | output | 1 | Decode register holds a real instruction |

## Verification
The fetch stream is driven from a memory model whose word is the bitwise inverse of its address, so every captured instruction reveals which address it came from. Straight-line runs separate a correct step size from an off-by-one in the increment; a forward and a backward branch in squash mode separate correct sign extension and the two-bit shift from a wrong target, while a held branch request over the resulting bubble shows whether bubbles are ignored. The same branch in delay mode distinguishes a kept slot from a squashed one, the pin toggled after reset shows whether the policy stays latched, and a branch offered under stall shows that the stall both freezes state and postpones the redirect.

// File: rtl/fu_pkg.sv
package fu_pkg;

    // Branch policy selected at reset
    typedef enum logic {
        POL_SQUASH = 1'b0,
        POL_DELAY  = 1'b1
    } policy_e;

endpackage

// File: rtl/fu_target.sv
// Branch target adder: base + (sign-extended word offset << 2)
module fu_target #(
    parameter int AW = 32,
    parameter int OW = 16
) (
    input  logic [AW-1:0] base_i,
    input  logic [OW-1:0] offset_i,
    output logic [AW-1:0] target_o
);
    localparam int EXT_W = AW - OW - 2;

    logic [AW-1:0] byte_off;

    generate
        if (EXT_W > 0) begin : g_ext
            assign byte_off = {{EXT_W{offset_i[OW-1]}}, offset_i, 2'b00};
        end else begin : g_trunc
            logic [OW+1:0] wide_off;
            assign wide_off = {offset_i, 2'b00};
            assign byte_off = wide_off[AW-1:0];
        end
    endgenerate

    assign target_o = base_i + byte_off;
endmodule

// File: rtl/fu_seq_inc.sv
// Sequential address incrementer
module fu_seq_inc #(
    parameter int AW       = 32,
    parameter int STEP_B   = 4
) (
    input  logic [AW-1:0] addr_i,
    output logic [AW-1:0] next_o
);
    localparam logic [AW-1:0] STEP = AW'(STEP_B);

    assign next_o = addr_i + STEP;
endmodule

// File: rtl/fu_redirect_ctl.sv
// Decides whether a branch in decode is accepted and whether the
// wrong-path word must be squashed.
module fu_redirect_ctl
    import fu_pkg::*;
(
    input  logic    stall_i,
    input  logic    br_taken_i,
    input  logic    dec_valid_i,
    input  policy_e policy_i,
    output logic    take_o,
    output logic    squash_o
);
    always_comb begin
        take_o   = br_taken_i && dec_valid_i && !stall_i;
        squash_o = take_o && (policy_i == POL_SQUASH);
    end
endmodule

// File: rtl/fu_fetch_unit.sv
module fu_fetch_unit
    import fu_pkg::*;
#(
    parameter int AW      = 32,
    parameter int IW      = 32,
    parameter int OW      = 16,
    parameter int STEP_B  = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_i,
    input  logic          stall_i,
    input  logic          br_taken_i,
    input  logic [OW-1:0] br_offset_i,
    input  logic [IW-1:0] instr_i,
    output logic [AW-1:0] fetch_addr_o,
    output logic [IW-1:0] ifid_instr_o,
    output logic [AW-1:0] ifid_pc4_o,
    output logic          ifid_valid_o
);
    typedef struct packed {
        logic [AW-1:0] pc;
        logic          valid;
        logic [IW-1:0] instr;
        logic [AW-1:0] pc4;
        policy_e       pol;
    } fetch_state_t;

    fetch_state_t st_d, st_q;

    logic [AW-1:0] seq_pc;
    logic [AW-1:0] tgt_pc;
    logic          take;
    logic          squash;
    policy_e       policy_q;

    assign policy_q = st_q.pol;

    fu_seq_inc #(.AW(AW), .STEP_B(STEP_B)) u_inc (
        .addr_i (st_q.pc),
        .next_o (seq_pc)
    );

    fu_target #(.AW(AW), .OW(OW)) u_tgt (
        .base_i   (st_q.pc4),
        .offset_i (br_offset_i),
        .target_o (tgt_pc)
    );

    fu_redirect_ctl u_ctl (
        .stall_i     (stall_i),
        .br_taken_i  (br_taken_i),
        .dec_valid_i (st_q.valid),
        .policy_i    (st_q.pol),
        .take_o      (take),
        .squash_o    (squash)
    );

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.pc    = '0;
            st_d.valid = 1'b0;
            st_d.instr = '0;
            st_d.pc4   = '0;
            st_d.pol   = policy_e'(mode_i);
        end else if (!stall_i) begin
            st_d.pc = take ? tgt_pc : seq_pc;
            if (squash) begin
                st_d.valid = 1'b0;
                st_d.instr = '0;
                st_d.pc4   = seq_pc;
            end else begin
                st_d.valid = 1'b1;
                st_d.instr = instr_i;
                st_d.pc4   = seq_pc;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign fetch_addr_o = st_q.pc;
    assign ifid_instr_o = st_q.instr;
    assign ifid_pc4_o   = st_q.pc4;
    assign ifid_valid_o = st_q.valid;
endmodule

// File: rtl/fu_fetch_chk.sv
module fu_fetch_chk
    import fu_pkg::*;
#(
    parameter int AW = 32,
    parameter int IW = 32,
    parameter int OW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          stall_i,
    input logic          br_taken_i,
    input logic [OW-1:0] br_offset_i,
    input logic [IW-1:0] instr_i,
    input logic [AW-1:0] fetch_addr_o,
    input logic [IW-1:0] ifid_instr_o,
    input logic [AW-1:0] ifid_pc4_o,
    input logic          ifid_valid_o,
    input policy_e       policy_q
);
    localparam logic [AW-1:0] STEP = AW'(4);

    logic [AW-1:0] exp_tgt;
    assign exp_tgt = ifid_pc4_o + {{(AW-OW-2){br_offset_i[OW-1]}}, br_offset_i, 2'b00};

    logic accept;
    assign accept = br_taken_i && ifid_valid_o && !stall_i && !rst;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (fetch_addr_o == '0 && !ifid_valid_o && ifid_pc4_o == '0));

    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && !accept) |=> (fetch_addr_o == $past(fetch_addr_o) + STEP
                                   && ifid_valid_o
                                   && ifid_instr_o == $past(instr_i)));

    // R3
    target_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> (fetch_addr_o == $past(exp_tgt)));

    // R4
    squash_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && policy_q == POL_SQUASH) |=> !ifid_valid_o);

    // R5
    delay_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && policy_q == POL_DELAY) |=> (ifid_valid_o
                                               && ifid_pc4_o == $past(fetch_addr_o) + STEP
                                               && ifid_instr_o == $past(instr_i)));

    // R6
    bubble_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && br_taken_i && !ifid_valid_o) |=> (fetch_addr_o == $past(fetch_addr_o) + STEP));

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        stall_i |=> ($stable(fetch_addr_o) && $stable(ifid_valid_o)
                     && $stable(ifid_instr_o) && $stable(ifid_pc4_o)));

    // R8
    policy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(policy_q));
endmodule

bind fu_fetch_unit fu_fetch_chk #(.AW(AW), .IW(IW), .OW(OW)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .stall_i      (stall_i),
    .br_taken_i   (br_taken_i),
    .br_offset_i  (br_offset_i),
    .instr_i      (instr_i),
    .fetch_addr_o (fetch_addr_o),
    .ifid_instr_o (ifid_instr_o),
    .ifid_pc4_o   (ifid_pc4_o),
    .ifid_valid_o (ifid_valid_o),
    .policy_q     (policy_q)
);

// File: tb/fu_fetch_unit_tb_top.sv
`timescale 1ns/100ps
module fu_fetch_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode = 1'b0;
    logic        stall = 1'b0;
    logic        br = 1'b0;
    logic [15:0] off = '0;
    logic [31:0] instr;
    logic [31:0] faddr, iinstr, ipc4;
    logic        ivalid;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    // ideal memory: word is the inverse of its address
    assign instr = ~faddr;

    fu_fetch_unit dut_i (
        .clk          (clk),
        .rst          (rst),
        .mode_i       (mode),
        .stall_i      (stall),
        .br_taken_i   (br),
        .br_offset_i  (off),
        .instr_i      (instr),
        .fetch_addr_o (faddr),
        .ifid_instr_o (iinstr),
        .ifid_pc4_o   (ipc4),
        .ifid_valid_o (ivalid)
    );

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic do_reset(logic m);
        rst = 1'b1; mode = m; stall = 1'b0; br = 1'b0; off = '0;
        cyc(); cyc();
        rst = 1'b0;
        mode = ~m;               // R8: must be ignored from here on
    endtask

    // R1, R2
    task automatic t_reset_seq();
        do_reset(1'b0);
        chk("R1", "fetch addr", faddr, 32'h0);
        chk("R1", "valid", {31'b0, ivalid}, 32'h0);
        chk("R1", "pc4", ipc4, 32'h0);
        for (int i = 1; i <= 4; i++) begin
            cyc();
            chk("R2", "fetch addr", faddr, 32'(4 * i));
            chk("R2", "instr", iinstr, ~32'(4 * (i - 1)));
            chk("R2", "pc4", ipc4, 32'(4 * i));
            chk("R2", "valid", {31'b0, ivalid}, 32'h1);
        end
        // reset beats stall and branch
        rst = 1'b1; stall = 1'b1; br = 1'b1; cyc();
        chk("R1", "fetch addr under stall", faddr, 32'h0);
        chk("R1", "valid under stall", {31'b0, ivalid}, 32'h0);
        rst = 1'b0; stall = 1'b0; br = 1'b0;
    endtask

    // R3, R4, R6, R8
    task automatic t_squash();
        do_reset(1'b0);
        cyc(); cyc(); cyc();               // fetch 12, decode holds word at 8
        br = 1'b1; off = 16'h0010;         // target 12 + 64
        cyc();
        chk("R3", "forward target", faddr, 32'd76);
        chk("R4", "squashed valid", {31'b0, ivalid}, 32'h0);
        chk("R4", "squashed instr", iinstr, 32'h0);
        cyc();                              // branch held over bubble
        chk("R6", "bubble ignores branch", faddr, 32'd80);
        chk("R6", "fetch resumes", iinstr, ~32'd76);
        chk("R6", "valid", {31'b0, ivalid}, 32'h1);
        off = 16'hFFFE;                     // -8 bytes from pc4 80
        cyc();
        chk("R3", "backward target", faddr, 32'd72);
        chk("R8", "policy stays squash", {31'b0, ivalid}, 32'h0);
        br = 1'b0; off = '0;
    endtask

    // R5, R8
    task automatic t_delay();
        do_reset(1'b1);
        cyc(); cyc(); cyc();               // fetch 12, decode pc4 12
        br = 1'b1; off = 16'h0004;         // target 12 + 16
        cyc();
        br = 1'b0;
        chk("R5", "target", faddr, 32'd28);
        chk("R5", "slot valid", {31'b0, ivalid}, 32'h1);
        chk("R5", "slot instr", iinstr, ~32'd12);
        chk("R5", "slot pc4", ipc4, 32'd16);
        cyc();
        chk("R5", "after slot addr", faddr, 32'd32);
        chk("R5", "target instr", iinstr, ~32'd28);
    endtask

    // R7
    task automatic t_stall();
        do_reset(1'b0);
        cyc(); cyc();                       // fetch 8, decode pc4 8
        stall = 1'b1; br = 1'b1; off = 16'h0008;
        cyc();
        chk("R7", "addr frozen", faddr, 32'd8);
        chk("R7", "instr frozen", iinstr, ~32'd4);
        chk("R7", "pc4 frozen", ipc4, 32'd8);
        cyc();
        chk("R7", "addr frozen 2", faddr, 32'd8);
        chk("R7", "valid frozen", {31'b0, ivalid}, 32'h1);
        stall = 1'b0;
        cyc();
        br = 1'b0;
        chk("R7", "branch after release", faddr, 32'd40);
        chk("R7", "squash after release", {31'b0, ivalid}, 32'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    endtask

    initial begin
        t_reset_seq();
        t_squash();
        t_delay();
        t_stall();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end
endmodule